// File: doc/BRIEF.md
# Multiprocessor-Wakeup UART Receiver

This block receives asynchronous serial frames on a multidrop line where every frame can carry one extra flag bit, the multiprocessor bit, placed after the eight data bits. A slave node on such a line normally sleeps through traffic meant for other nodes. Software arms a wakeup-enable bit. From then on the receiver discards every frame whose multiprocessor bit is 0. When a frame arrives with that bit set (an address frame), the receiver clears the wakeup-enable bit by itself, records the multiprocessor bit and handles that frame as a normal reception. Software can then read the address and decide whether to stay awake.

The receiver looks for a start bit with a 16x oversampling tick that comes from an external baud generator. It confirms the start bit with a sample at the middle of the bit and then samples every later bit at its centre. A finished frame is moved into a data register, and the receiver raises a data-full flag, a framing-error flag, an overrun flag and a received-multiprocessor-bit flag. It also outputs a receive interrupt request and an error interrupt request, and each one has its own enable input. A mode input picks asynchronous or synchronous operation. This block only uses it to decide whether the wakeup filter applies, because the clocked synchronous datapath lives elsewhere.

Top module: `mpw_uart_rx`

## Requirements
- R1: When `rx_en` is 1, a low level on the line starts a candidate frame. The candidate is confirmed only if the line is still low 8 sample ticks later, at the middle of the start bit. A shorter low pulse is dropped and produces nothing.
- R2: A frame is one start bit (0), then 8 data bits with the LSB first, then one multiprocessor bit when `mp_fmt` is 1, then one stop bit. Each bit lasts 16 sample ticks. An accepted frame with `rdf` at 0 loads its data into `rx_data` and sets `rdf`.
- R3: An accepted frame whose stop bit is sampled low sets `fer`.
- R4: An accepted frame that completes while `rdf` is 1 sets `ovr` and leaves `rx_data` unchanged.
- R5: The filter is active only when `wake_en`, `async_mode` and `mp_fmt` are all 1. While it is active, a frame with multiprocessor bit 0 changes nothing: `rx_data`, `rdf`, `fer`, `ovr`, `mpb` and `wake_en` all keep their values.
- R6: While the filter is active, a frame with multiprocessor bit 1 clears `wake_en` to 0 and sets `mpb` to 1. That frame is then handled as an accepted frame, so R2 to R4 apply to it.
- R7: When `async_mode` is 0 or `mp_fmt` is 0, `wake_en` has no effect. Every frame is accepted and `wake_en` keeps its value.
- R8: While `rx_en` is 0, no frame is received and `rx_data`, `rdf`, `fer`, `ovr` and `mpb` keep their values.
- R9: `rxi_irq` is high exactly when `rdf` and `rxi_en` are both 1. `eri_irq` is high exactly when `eri_en` is 1 and `fer` or `ovr` is 1.
- R10: `wake_en` resets to 0. A pulse on `wake_wr` loads `wake_wdata` into it. If that write falls in the same cycle as a hardware clear, the write wins.
- R11: `rdf_clr` clears `rdf`, and `err_clr` clears both `fer` and `ovr`. If a set and a clear of the same flag fall in the same cycle, the set wins.
- R12: Every accepted frame loads its multiprocessor bit into `mpb`. When `mp_fmt` is 0, `mpb` is loaded with 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rxd | input | 1 | Serial line, idle high |
| rx_en | input | 1 | Receive enable |
| async_mode | input | 1 | 1 = asynchronous mode, 0 = synchronous mode |
| mp_fmt | input | 1 | 1 = frames carry a multiprocessor bit |
| wake_wr | input | 1 | Write strobe for the wakeup-enable bit |
| wake_wdata | input | 1 | Value written to the wakeup-enable bit |
| rdf_clr | input | 1 | Clears the data-full flag |
| err_clr | input | 1 | Clears the framing-error and overrun flags |
| rxi_en | input | 1 | Receive interrupt enable |
| eri_en | input | 1 | Error interrupt enable |
| rx_data | output | 8 | Received data register |
| rdf | output | 1 | Data-full flag |
| fer | output | 1 | Framing-error flag |
| ovr | output | 1 | Overrun flag |
| mpb | output | 1 | Multiprocessor bit of the last accepted frame |
| wake_en | output | 1 | Current wakeup-enable bit |
| rxi_irq | output | 1 | Receive interrupt request |
| eri_irq | output | 1 | Error interrupt request |

## Verification
The checker watches the frame-completion event inside the block on every cycle. It checks that a suppressed frame never raises a flag or changes the data register, that a wakeup frame clears the wakeup bit and sets `mpb`, that overrun keeps the old data, that a bad stop bit sets `fer`, that flags hold while reception is disabled, and that interrupts stay low when their enables are off. Only the bench scenarios can show bit order and centre sampling, which are checked through the assembled byte values. The same goes for the rejection of a short start glitch and for the full sequences: an address frame followed by an overrun, and a filter that is armed in synchronous mode or without multiprocessor format.

// File: rtl/mpw_uart_rx_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the multiprocessor-wakeup receiver.
// Assumes: it is compiled ahead of every module of the receiver.
package mpw_uart_rx_pkg;

    // Phase of the frame engine within one serial frame.
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_START = 3'd1,
        PH_DATA  = 3'd2,
        PH_MPBIT = 3'd3,
        PH_STOP  = 3'd4
    } rx_phase_t;

endpackage

// File: rtl/mpw_rx_sync.sv
`timescale 1ns/1ps
// Module: mpw_rx_sync
// Brings the asynchronous serial line into the clock domain through a
// chain of flip-flops.
// Assumes: STAGES >= 1, and the line idles high, so reset loads ones.
module mpw_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First stage samples the raw line.
            always_ff @(posedge clk) begin
                if (!rst_n) q[0] <= 1'b1;
                else        q[0] <= din;
            end
        end else begin : g_next
            // Later stages settle metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) q[i] <= 1'b1;
                else        q[i] <= q[i-1];
            end
        end
    end

    assign dout = q[STAGES-1];

endmodule

// File: rtl/mpw_rx_frame.sv
`timescale 1ns/1ps
// Module: mpw_rx_frame
// Oversampled frame engine. It detects a falling edge on the line and
// confirms the start bit half a bit later. It then samples each data bit,
// the optional multiprocessor bit and the stop bit at their centres, and
// pulses done for one cycle with the assembled frame.
// Assumes: tick is a one-cycle pulse at OSR times the bit rate, OSR is
// even, and rxd_s is already synchronous. Dropping rx_en aborts a frame.
module mpw_rx_frame
    import mpw_uart_rx_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int OSR       = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_en,
    input  logic                 tick,
    input  logic                 rxd_s,
    input  logic                 mp_fmt,
    output logic                 done,
    output logic [DATA_BITS-1:0] data,
    output logic                 mp_bit,
    output logic                 stop_ok
);

    localparam int CW       = (OSR > 2) ? $clog2(OSR) : 1;
    localparam int BW       = $clog2(DATA_BITS + 1);
    localparam int HALF_END = OSR / 2 - 1;
    localparam int FULL_END = OSR - 1;
    localparam int LAST_BIT = DATA_BITS - 1;

    rx_phase_t             phase;
    logic [CW-1:0]         tcnt;
    logic [BW-1:0]         bidx;
    logic [DATA_BITS-1:0]  shreg;
    logic                  at_half;
    logic                  at_full;

    assign at_half = (tcnt == CW'(HALF_END));
    assign at_full = (tcnt == CW'(FULL_END));
    assign data    = shreg;

    // Frame sequencing: phase, tick counter, bit index and captured bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            tcnt    <= '0;
            bidx    <= '0;
            shreg   <= '0;
            mp_bit  <= 1'b0;
            stop_ok <= 1'b1;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!rx_en) begin
                phase <= PH_IDLE;
                tcnt  <= '0;
            end else if (tick) begin
                unique case (phase)
                    PH_IDLE: begin
                        if (!rxd_s) begin
                            phase <= PH_START;
                            tcnt  <= '0;
                        end
                    end
                    PH_START: begin
                        if (at_half) begin
                            tcnt <= '0;
                            bidx <= '0;
                            phase <= rxd_s ? PH_IDLE : PH_DATA;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    PH_DATA: begin
                        if (at_full) begin
                            tcnt  <= '0;
                            shreg <= {rxd_s, shreg[DATA_BITS-1:1]};
                            if (bidx == BW'(LAST_BIT)) begin
                                if (mp_fmt) begin
                                    phase <= PH_MPBIT;
                                end else begin
                                    phase  <= PH_STOP;
                                    mp_bit <= 1'b0;
                                end
                            end else begin
                                bidx <= bidx + 1'b1;
                            end
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    PH_MPBIT: begin
                        if (at_full) begin
                            tcnt   <= '0;
                            mp_bit <= rxd_s;
                            phase  <= PH_STOP;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    PH_STOP: begin
                        if (at_full) begin
                            tcnt    <= '0;
                            stop_ok <= rxd_s;
                            done    <= 1'b1;
                            phase   <= PH_IDLE;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/mpw_rx_status.sv
`timescale 1ns/1ps
// Module: mpw_rx_status
// Wakeup filter, data register, status flags and interrupt gating.
// It decides whether a completed frame is accepted, loads the data
// register, updates the flags and keeps the self-clearing wakeup bit.
// Assumes: take is a one-cycle pulse per completed frame while reception
// is enabled. Sets beat clears, and a software write beats the hardware
// wakeup clear.
module mpw_rx_status #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 take,
    input  logic [DATA_BITS-1:0] frm_data,
    input  logic                 frm_mpb,
    input  logic                 frm_stop_ok,
    input  logic                 async_mode,
    input  logic                 mp_fmt,
    input  logic                 wake_wr,
    input  logic                 wake_wdata,
    input  logic                 rdf_clr,
    input  logic                 err_clr,
    input  logic                 rxi_en,
    input  logic                 eri_en,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rdf,
    output logic                 fer,
    output logic                 ovr,
    output logic                 mpb,
    output logic                 wake_en,
    output logic                 rxi_irq,
    output logic                 eri_irq
);

    logic filt_on;
    logic accept;
    logic wake_hit;

    // The filter is live only for asynchronous multiprocessor framing.
    assign filt_on  = wake_en & async_mode & mp_fmt;
    assign accept   = take & (~filt_on | frm_mpb);
    assign wake_hit = take & filt_on & frm_mpb;

    // Data register: loaded only when an accepted frame finds it empty.
    always_ff @(posedge clk) begin
        if (!rst_n)               rx_data <= '0;
        else if (accept && !rdf)  rx_data <= frm_data;
    end

    // Data-full flag: set on a fresh accepted frame, cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n)               rdf <= 1'b0;
        else if (accept && !rdf)  rdf <= 1'b1;
        else if (rdf_clr)         rdf <= 1'b0;
    end

    // Overrun flag: an accepted frame that finds the register still full.
    always_ff @(posedge clk) begin
        if (!rst_n)               ovr <= 1'b0;
        else if (accept && rdf)   ovr <= 1'b1;
        else if (err_clr)         ovr <= 1'b0;
    end

    // Framing-error flag: an accepted frame whose stop bit was low.
    always_ff @(posedge clk) begin
        if (!rst_n)                     fer <= 1'b0;
        else if (accept && !frm_stop_ok) fer <= 1'b1;
        else if (err_clr)               fer <= 1'b0;
    end

    // Multiprocessor-bit flag: follows the last accepted frame.
    always_ff @(posedge clk) begin
        if (!rst_n)      mpb <= 1'b0;
        else if (accept) mpb <= frm_mpb;
    end

    // Wakeup-enable: software write first, then the hardware self-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        wake_en <= 1'b0;
        else if (wake_wr)  wake_en <= wake_wdata;
        else if (wake_hit) wake_en <= 1'b0;
    end

    // Interrupt requests follow the flags, gated by their enables.
    assign rxi_irq = rdf & rxi_en;
    assign eri_irq = (fer | ovr) & eri_en;

endmodule

// File: rtl/mpw_uart_rx.sv
`timescale 1ns/1ps
// Module: mpw_uart_rx (top)
// Multiprocessor-wakeup asynchronous receiver. It chains the line
// synchronizer, the oversampled frame engine and the filter/status unit.
// Assumes: sample_tick comes from an external baud generator at OSR
// times the bit rate. In synchronous mode only the wakeup filter is
// disabled, and the clocked datapath sits outside this block.
module mpw_uart_rx #(
    parameter int DATA_BITS   = 8,
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample_tick,
    input  logic                 rxd,
    input  logic                 rx_en,
    input  logic                 async_mode,
    input  logic                 mp_fmt,
    input  logic                 wake_wr,
    input  logic                 wake_wdata,
    input  logic                 rdf_clr,
    input  logic                 err_clr,
    input  logic                 rxi_en,
    input  logic                 eri_en,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rdf,
    output logic                 fer,
    output logic                 ovr,
    output logic                 mpb,
    output logic                 wake_en,
    output logic                 rxi_irq,
    output logic                 eri_irq
);

    logic                 rxd_s;
    logic                 frm_done;
    logic [DATA_BITS-1:0] frm_data;
    logic                 frm_mpb;
    logic                 frm_stop_ok;
    logic                 frm_take;

    mpw_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rxd),
        .dout  (rxd_s)
    );

    mpw_rx_frame #(.DATA_BITS(DATA_BITS), .OSR(OSR)) i_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_en   (rx_en),
        .tick    (sample_tick),
        .rxd_s   (rxd_s),
        .mp_fmt  (mp_fmt),
        .done    (frm_done),
        .data    (frm_data),
        .mp_bit  (frm_mpb),
        .stop_ok (frm_stop_ok)
    );

    // A frame counts only while reception is still enabled.
    assign frm_take = frm_done & rx_en;

    mpw_rx_status #(.DATA_BITS(DATA_BITS)) i_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .take        (frm_take),
        .frm_data    (frm_data),
        .frm_mpb     (frm_mpb),
        .frm_stop_ok (frm_stop_ok),
        .async_mode  (async_mode),
        .mp_fmt      (mp_fmt),
        .wake_wr     (wake_wr),
        .wake_wdata  (wake_wdata),
        .rdf_clr     (rdf_clr),
        .err_clr     (err_clr),
        .rxi_en      (rxi_en),
        .eri_en      (eri_en),
        .rx_data     (rx_data),
        .rdf         (rdf),
        .fer         (fer),
        .ovr         (ovr),
        .mpb         (mpb),
        .wake_en     (wake_en),
        .rxi_irq     (rxi_irq),
        .eri_irq     (eri_irq)
    );

endmodule

// File: rtl/mpw_uart_rx_chk.sv
`timescale 1ns/1ps
// Module: mpw_uart_rx_chk
// Cycle-by-cycle properties of the receiver, bound into the top module.
// Assumes: it sees the frame-completion event between the engine and the
// status unit.
module mpw_uart_rx_chk #(
    parameter int DATA_BITS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rx_en,
    input logic                 async_mode,
    input logic                 mp_fmt,
    input logic                 wake_wr,
    input logic                 wake_wdata,
    input logic                 rxi_en,
    input logic                 eri_en,
    input logic [DATA_BITS-1:0] rx_data,
    input logic                 rdf,
    input logic                 fer,
    input logic                 ovr,
    input logic                 mpb,
    input logic                 wake_en,
    input logic                 rxi_irq,
    input logic                 eri_irq,
    input logic                 frm_done,
    input logic                 frm_mpb,
    input logic                 frm_stop_ok
);

    logic filt;
    assign filt = wake_en && async_mode && mp_fmt;

    // R5: a filtered frame without the multiprocessor bit changes nothing.
    p_suppress_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && rx_en && filt && !frm_mpb)
        |=> (!$rose(rdf) && !$rose(fer) && !$rose(ovr) && $stable(rx_data)));

    // R6: an address frame under the filter wakes the receiver.
    p_wake_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && rx_en && filt && frm_mpb && !wake_wr)
        |=> (!wake_en && mpb));

    // R7: outside asynchronous multiprocessor framing the bit holds.
    p_wake_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_en && !(async_mode && mp_fmt) && !wake_wr) |=> wake_en);

    // R4: an overrun keeps the earlier data.
    p_ovr_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && rx_en && rdf && !filt) |=> (ovr && $stable(rx_data)));

    // R3: a low stop bit on an accepted frame flags a framing error.
    p_fer_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && rx_en && !frm_stop_ok && !filt) |=> fer);

    // R8: no flag rises while reception is disabled.
    p_rx_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (!$rose(rdf) && !$rose(fer) && !$rose(ovr) && !$rose(mpb)));

    // R9: interrupt requests stay low with their enables off.
    p_rxi_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rxi_en |-> !rxi_irq);
    p_eri_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !eri_en |-> !eri_irq);

    // R10: a software write lands in the wakeup bit.
    p_wake_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wake_wr |=> (wake_en == $past(wake_wdata)));

endmodule

bind mpw_uart_rx mpw_uart_rx_chk #(.DATA_BITS(DATA_BITS)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_en       (rx_en),
    .async_mode  (async_mode),
    .mp_fmt      (mp_fmt),
    .wake_wr     (wake_wr),
    .wake_wdata  (wake_wdata),
    .rxi_en      (rxi_en),
    .eri_en      (eri_en),
    .rx_data     (rx_data),
    .rdf         (rdf),
    .fer         (fer),
    .ovr         (ovr),
    .mpb         (mpb),
    .wake_en     (wake_en),
    .rxi_irq     (rxi_irq),
    .eri_irq     (eri_irq),
    .frm_done    (frm_done),
    .frm_mpb     (frm_mpb),
    .frm_stop_ok (frm_stop_ok)
);

// File: tb/test_mpw_uart_rx.sv
`timescale 1ns/1ps
// Bench for mpw_uart_rx: a vector table of frames and expected register
// state, then directed tests for reset, glitches, enables and interrupts.
module test_mpw_uart_rx;

    localparam int BIT_CLK = 32;   // 16 ticks, one tick every 2 clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       rx_en = 1'b0;
    logic       async_mode = 1'b1;
    logic       mp_fmt = 1'b1;
    logic       wake_wr = 1'b0;
    logic       wake_wdata = 1'b0;
    logic       rdf_clr = 1'b0;
    logic       err_clr = 1'b0;
    logic       rxi_en = 1'b0;
    logic       eri_en = 1'b0;
    logic [7:0] rx_data;
    logic       rdf, fer, ovr, mpb, wake_en, rxi_irq, eri_irq;

    int n_tests = 0;
    int n_fail  = 0;

    mpw_uart_rx i_mpw_uart_rx (
        .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .rxd(rxd),
        .rx_en(rx_en), .async_mode(async_mode), .mp_fmt(mp_fmt),
        .wake_wr(wake_wr), .wake_wdata(wake_wdata), .rdf_clr(rdf_clr),
        .err_clr(err_clr), .rxi_en(rxi_en), .eri_en(eri_en),
        .rx_data(rx_data), .rdf(rdf), .fer(fer), .ovr(ovr), .mpb(mpb),
        .wake_en(wake_en), .rxi_irq(rxi_irq), .eri_irq(eri_irq)
    );

    always #10 clk = ~clk;

    always @(posedge clk) sample_tick <= ~sample_tick;

    // Vector layout: [26] clear flags, [25] arm wakeup, [24] mp_fmt,
    // [23] async_mode, [22:15] data, [14] mp bit, [13] stop bit,
    // [12] rdf, [11] fer, [10] ovr, [9] mpb, [8] wake_en, [7:0] rx_data.
    localparam logic [26:0] VEC [8] = '{
        {1'b1,1'b0,1'b1,1'b1,8'hA5,1'b0,1'b1, 1'b1,1'b0,1'b0,1'b0,1'b0,8'hA5},
        {1'b1,1'b1,1'b1,1'b1,8'h11,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b1,8'hA5},
        {1'b0,1'b0,1'b1,1'b1,8'h5A,1'b1,1'b1, 1'b1,1'b0,1'b0,1'b1,1'b0,8'h5A},
        {1'b0,1'b0,1'b1,1'b1,8'h77,1'b0,1'b1, 1'b1,1'b0,1'b1,1'b0,1'b0,8'h5A},
        {1'b1,1'b1,1'b1,1'b0,8'hC3,1'b0,1'b1, 1'b1,1'b0,1'b0,1'b0,1'b1,8'hC3},
        {1'b1,1'b0,1'b0,1'b1,8'h96,1'b1,1'b1, 1'b1,1'b0,1'b0,1'b0,1'b1,8'h96},
        {1'b1,1'b0,1'b1,1'b1,8'hE7,1'b1,1'b0, 1'b1,1'b1,1'b0,1'b1,1'b0,8'hE7},
        {1'b1,1'b0,1'b1,1'b1,8'h0F,1'b0,1'b1, 1'b1,1'b0,1'b0,1'b0,1'b0,8'h0F}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold_bit(input logic v);
        rxd = v;
        repeat (BIT_CLK) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic with_mp, input logic mpv, input logic stopv);
        hold_bit(1'b0);
        for (int i = 0; i < 8; i++) hold_bit(d[i]);
        if (with_mp) hold_bit(mpv);
        hold_bit(stopv);
        rxd = 1'b1;
        repeat (BIT_CLK) @(negedge clk);
    endtask

    task automatic clear_flags();
        rdf_clr = 1'b1; err_clr = 1'b1;
        @(negedge clk);
        rdf_clr = 1'b0; err_clr = 1'b0;
    endtask

    task automatic write_wake(input logic v);
        wake_wr = 1'b1; wake_wdata = v;
        @(negedge clk);
        wake_wr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state (R10 for the wakeup bit)
        chk("R2 reset rdf", rdf, 0);
        chk("R3 reset fer", fer, 0);
        chk("R4 reset ovr", ovr, 0);
        chk("R12 reset mpb", mpb, 0);
        chk("R10 reset wake_en", wake_en, 0);
        chk("R2 reset rx_data", rx_data, 0);
        chk("R9 reset irqs", {rxi_irq, eri_irq}, 0);

        rx_en = 1'b1;
        repeat (4) @(negedge clk);

        // Vector table: R2 R3 R4 R5 R6 R7 R12
        for (int v = 0; v < 8; v++) begin
            mp_fmt = VEC[v][24];
            async_mode = VEC[v][23];
            if (VEC[v][26]) clear_flags();
            if (VEC[v][25]) write_wake(1'b1);
            send(VEC[v][22:15], VEC[v][24], VEC[v][14], VEC[v][13]);
            chk("R2/R4/R5 rx_data", rx_data, VEC[v][7:0]);
            chk("R2/R5 rdf", rdf, VEC[v][12]);
            chk("R3/R5 fer", fer, VEC[v][11]);
            chk("R4/R5 ovr", ovr, VEC[v][10]);
            chk("R6/R12 mpb", mpb, VEC[v][9]);
            chk("R6/R7 wake_en", wake_en, VEC[v][8]);
        end

        // R9: interrupt gating on existing flags (rdf=1, no errors)
        rxi_en = 1'b1; eri_en = 1'b1;
        @(negedge clk);
        chk("R9 rxi with enable", rxi_irq, 1);
        chk("R9 eri no error", eri_irq, 0);
        rxi_en = 1'b0;
        @(negedge clk);
        chk("R9 rxi masked", rxi_irq, 0);

        // R4 + R9: overrun raises the error request
        send(8'h22, 1'b1, 1'b0, 1'b1);
        chk("R4 ovr set", ovr, 1);
        chk("R4 data kept", rx_data, 8'h0F);
        chk("R9 eri on overrun", eri_irq, 1);
        eri_en = 1'b0;
        @(negedge clk);
        chk("R9 eri masked", eri_irq, 0);

        // R8: disabled receiver ignores a frame and keeps its flags
        rx_en = 1'b0;
        send(8'h44, 1'b1, 1'b1, 1'b0);
        chk("R8 data kept", rx_data, 8'h0F);
        chk("R8 flags kept", {rdf, fer, ovr, mpb}, 4'b1010);

        // R11: separate clears
        rdf_clr = 1'b1; @(negedge clk); rdf_clr = 1'b0;
        chk("R11 rdf cleared", rdf, 0);
        chk("R11 ovr untouched by rdf_clr", ovr, 1);
        err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
        chk("R11 ovr cleared", ovr, 0);

        // R1: short low glitch is dropped, then a real frame is received
        rx_en = 1'b1;
        repeat (4) @(negedge clk);
        rxd = 1'b0;
        repeat (8) @(negedge clk);
        rxd = 1'b1;
        repeat (3 * BIT_CLK) @(negedge clk);
        chk("R1 glitch ignored", rdf, 0);
        send(8'h81, 1'b1, 1'b0, 1'b1);
        chk("R1 frame after glitch", rx_data, 8'h81);
        chk("R1 rdf after glitch", rdf, 1);

        // R10: software set and clear of the wakeup bit
        write_wake(1'b1);
        chk("R10 write one", wake_en, 1);
        write_wake(1'b0);
        chk("R10 write zero", wake_en, 0);

        // R5 + R9: a suppressed bad frame raises no request
        clear_flags();
        write_wake(1'b1);
        rxi_en = 1'b1; eri_en = 1'b1;
        send(8'h3C, 1'b1, 1'b0, 1'b0);
        chk("R5 no rxi while filtered", rxi_irq, 0);
        chk("R5 no eri while filtered", eri_irq, 0);
        chk("R5 wake still armed", wake_en, 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule